// File: doc/BRIEF.md
# Two-Port Cell Bus Receive Responder

This block is the physical-layer end of a UTOPIA Level 2 receive path. It presents two logical PHY ports on one shared bus: port 0 is the fast channel and port 1 is the interleaved channel. Each port has its own 5-bit address, set through a configuration input. An ATM-layer master drives a 5-bit address bus and an active-low enable. The block answers address polls on one shared cell-available line. Once the master has selected a port, the block streams that port's 53-byte cell, one byte per clock, onto an 8-bit data bus. A start-of-cell flag marks the first byte.

Cell storage lies outside the block. Each port's buffer raises a one-cycle load pulse when it holds a complete cell. The block then sets that port's ready flag. It reads bytes back through a combinational read port: a one-hot read strobe plus a byte offset. Every bus output is registered. The cell-available line and the data bus each have an output-enable. Driving an output-enable low stands for releasing the shared line.

Top module: `cellbus_rx_phy`

## Requirements
- R1: While reset is active, and after it is released with no stimulus, `bus_clav_oe`, `bus_data_oe`, `bus_soc` and `bus_clav` are 0, and no port reports a cell.
- R2: When `bus_addr` matches a port's address at a clock edge, then after that edge `bus_clav_oe` is 1 and `bus_clav` equals that port's ready flag as it stood before the edge. This holds for any level of `bus_enb_n`.
- R3: When `bus_addr` matches no port at a clock edge, `bus_clav_oe` is 0 after that edge.
- R4: A select is an edge with `bus_enb_n` high and a matching address, followed by an edge with `bus_enb_n` low. That port becomes the source, and its first byte is driven (`bus_data_oe`=1) after the edge that sampled enable low.
- R5: Each edge with enable low, while a ready port is selected, drives exactly one byte. That byte is the buffer byte at the port's current offset (0..52). The offset then advances, and it wraps to 0 after 52.
- R6: `bus_soc` is 1 exactly when the driven byte has offset 0, and it is 0 whenever `bus_data_oe` is 0.
- R7: An edge with enable high in the middle of a cell drives no byte and leaves the offset unchanged. Re-selecting the port resumes at that same offset.
- R8: A load pulse sets a port's ready flag. Transferring offset 52 clears the flag, unless a load pulse for that port falls on the same edge, in which case the flag stays set.
- R9: A select whose address matches no port leaves the block with no source. No byte is driven until the next valid select.
- R10: Each port keeps its own offset. Switching the selection to the other port and back resumes each port where it stopped.
- R11: A selected port whose ready flag is clear drives no byte while enable is low.
- R12: If both ports carry the same address, port 0 answers polls and is the one selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock from the ATM-layer side |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 10 | Port addresses, port 0 in bits 4:0, port 1 in bits 9:5 |
| cell_load | input | 2 | Per-port pulse: the buffer now holds a complete cell |
| buf_rd_data | input | 16 | Per-port byte at `buf_rd_off`, port 0 in bits 7:0 |
| buf_rd_en | output | 2 | One-hot strobe: the byte of this port is taken this edge |
| buf_rd_off | output | 6 | Offset being read from the current source port |
| bus_addr | input | 5 | Address from the master |
| bus_enb_n | input | 1 | Active-low enable from the master |
| bus_clav | output | 1 | Shared cell-available answer |
| bus_clav_oe | output | 1 | Drive enable for `bus_clav` |
| bus_data | output | 8 | Cell byte |
| bus_soc | output | 1 | Start-of-cell flag |
| bus_data_oe | output | 1 | Drive enable for `bus_data` and `bus_soc` |

## Verification
Two events can land on the same edge: the transfer of a port's last byte, which clears its ready flag, and a fresh load pulse for that same port, which sets it. The bench raises the load pulse on the very edge that sends offset 52. It then expects an immediate poll of that port to answer 1, and expects the byte that follows to restart at offset 0 with the start-of-cell flag set. The opposite case is covered by streaming the other port's last byte with no load pulse. After that, a poll must answer 0 and enable held low must drive no byte.

// File: rtl/cellbus_pkg.sv
package cellbus_pkg;
  // bytes in one cell on the bus
  localparam int unsigned CELL_LEN  = 53;
  localparam int unsigned ADDR_BITS = 5;
  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned PORT_CNT  = 2;
endpackage

// File: rtl/cellbus_addr_match.sv
module cellbus_addr_match #(
  parameter int NPORT = 2,
  parameter int AW    = 5,
  parameter int IW    = 1
) (
  input  logic [AW-1:0]       addr,
  input  logic [NPORT*AW-1:0] cfg_addr,
  output logic                hit,
  output logic [IW-1:0]       idx
);
  logic [NPORT-1:0] eq;

  for (genvar p = 0; p < NPORT; p++) begin : g_cmp
    assign eq[p] = (addr == cfg_addr[p*AW +: AW]);
  end

  // lowest port index wins on duplicate addresses
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (eq[p]) begin
        hit = 1'b1;
        idx = IW'(p);
      end
    end
  end
endmodule

// File: rtl/cellbus_port_ctx.sv
module cellbus_port_ctx #(
  parameter int CELL_BYTES = 53,
  parameter int OFF_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  output logic             ready,
  output logic [OFF_W-1:0] off
);
  logic             last;
  logic             ready_nx;
  logic [OFF_W-1:0] off_nx;

  assign last = (off == OFF_W'(CELL_BYTES - 1));

  always_comb begin
    off_nx   = off;
    ready_nx = ready;
    if (adv) begin
      off_nx = last ? '0 : OFF_W'(off + 1'b1);
      if (last) ready_nx = 1'b0;
    end
    if (load) ready_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      off   <= '0;
    end else begin
      ready <= ready_nx;
      if (adv) off <= off_nx;
    end
  end
endmodule

// File: rtl/cellbus_rx_phy.sv
module cellbus_rx_phy #(
  parameter int NPORT      = cellbus_pkg::PORT_CNT,
  parameter int AW         = cellbus_pkg::ADDR_BITS,
  parameter int DW         = cellbus_pkg::BYTE_BITS,
  parameter int CELL_BYTES = cellbus_pkg::CELL_LEN,
  localparam int OFF_W     = $clog2(CELL_BYTES),
  localparam int IW        = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT*AW-1:0] cfg_addr,
  input  logic [NPORT-1:0]    cell_load,
  input  logic [NPORT*DW-1:0] buf_rd_data,
  output logic [NPORT-1:0]    buf_rd_en,
  output logic [OFF_W-1:0]    buf_rd_off,
  input  logic [AW-1:0]       bus_addr,
  input  logic                bus_enb_n,
  output logic                bus_clav,
  output logic                bus_clav_oe,
  output logic [DW-1:0]       bus_data,
  output logic                bus_soc,
  output logic                bus_data_oe
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // address decode of the current bus cycle
  logic          hit;
  logic [IW-1:0] hit_idx;

  cellbus_addr_match #(.NPORT(NPORT), .AW(AW), .IW(IW)) u_match (
    .addr    (bus_addr),
    .cfg_addr(cfg_addr),
    .hit     (hit),
    .idx     (hit_idx)
  );

  // per-port context
  logic [NPORT-1:0] ready;
  logic [NPORT-1:0] adv;
  logic [OFF_W-1:0] off [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    cellbus_port_ctx #(.CELL_BYTES(CELL_BYTES), .OFF_W(OFF_W)) u_ctx (
      .clk  (clk),
      .rst_n(rst_q_n),
      .load (cell_load[p]),
      .adv  (adv[p]),
      .ready(ready[p]),
      .off  (off[p])
    );
  end

  // state
  logic          enb_n_q;
  logic          pend_hit_q;
  logic [IW-1:0] pend_idx_q;
  logic          act_vld_q;
  logic [IW-1:0] act_idx_q;
  logic          clav_q, clav_oe_q;
  logic [DW-1:0] data_q;
  logic          soc_q, data_oe_q;

  // next-state
  logic          sel_now;
  logic          eff_vld;
  logic [IW-1:0] eff_idx;
  logic          xfer;
  logic          clav_nx, soc_nx;
  logic [DW-1:0] data_nx;

  always_comb begin
    sel_now = enb_n_q & ~bus_enb_n;
    eff_vld = sel_now ? pend_hit_q : act_vld_q;
    eff_idx = sel_now ? pend_idx_q : act_idx_q;
    xfer    = ~bus_enb_n & eff_vld & ready[eff_idx];
    clav_nx = hit & ready[hit_idx];
    data_nx = buf_rd_data[eff_idx*DW +: DW];
    soc_nx  = (off[eff_idx] == '0);
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_adv
    assign adv[p] = xfer && (eff_idx == IW'(p));
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      enb_n_q    <= 1'b1;
      pend_hit_q <= 1'b0;
      pend_idx_q <= '0;
      act_vld_q  <= 1'b0;
      act_idx_q  <= '0;
      clav_q     <= 1'b0;
      clav_oe_q  <= 1'b0;
      data_q     <= '0;
      soc_q      <= 1'b0;
      data_oe_q  <= 1'b0;
    end else begin
      enb_n_q    <= bus_enb_n;
      pend_hit_q <= hit;
      pend_idx_q <= hit_idx;
      if (sel_now) begin
        act_vld_q <= pend_hit_q;
        act_idx_q <= pend_idx_q;
      end
      clav_oe_q <= hit;
      clav_q    <= clav_nx;
      data_oe_q <= xfer;
      soc_q     <= xfer & soc_nx;
      if (xfer) data_q <= data_nx;
    end
  end

  assign buf_rd_en   = adv;
  assign buf_rd_off  = off[eff_idx];
  assign bus_clav    = clav_q;
  assign bus_clav_oe = clav_oe_q;
  assign bus_data    = data_q;
  assign bus_soc     = soc_q;
  assign bus_data_oe = data_oe_q;
endmodule

// File: rtl/cellbus_rx_phy_chk.sv
module cellbus_rx_phy_chk #(
  parameter int NPORT = 2,
  parameter int AW    = 5,
  parameter int OFF_W = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NPORT*AW-1:0] cfg_addr,
  input logic [AW-1:0]       bus_addr,
  input logic                bus_enb_n,
  input logic [NPORT-1:0]    buf_rd_en,
  input logic [OFF_W-1:0]    buf_rd_off,
  input logic                bus_clav_oe,
  input logic                bus_soc,
  input logic                bus_data_oe
);
  logic       hit;
  logic [1:0] armed;

  always_comb begin
    hit = 1'b0;
    for (int p = 0; p < NPORT; p++)
      if (bus_addr == cfg_addr[p*AW +: AW]) hit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 2'b00;
    else        armed <= {armed[0], 1'b1};
  end

  // R2
  poll_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed[0] && $past(hit)) |-> bus_clav_oe);

  // R3
  poll_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed[0] && !$past(hit)) |-> !bus_clav_oe);

  // R4
  data_after_enb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> $past(!bus_enb_n));

  // R6
  soc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_soc |-> bus_data_oe);

  // R5
  one_reader_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(buf_rd_en));

  // R7
  offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed[0] && bus_enb_n && $past(bus_enb_n)) |-> $stable(buf_rd_off));

  // R9
  null_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed[1] && $past(bus_enb_n, 2) && !$past(bus_enb_n) && !$past(hit, 2))
      |-> !bus_data_oe);
endmodule

bind cellbus_rx_phy cellbus_rx_phy_chk #(.NPORT(NPORT), .AW(AW), .OFF_W(OFF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .cfg_addr   (cfg_addr),
  .bus_addr   (bus_addr),
  .bus_enb_n  (bus_enb_n),
  .buf_rd_en  (buf_rd_en),
  .buf_rd_off (buf_rd_off),
  .bus_clav_oe(bus_clav_oe),
  .bus_soc    (bus_soc),
  .bus_data_oe(bus_data_oe)
);

// File: tb/cellbus_rx_phy_bench.sv
module cellbus_rx_phy_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  cfg_addr = {5'd9, 5'd3};
  logic [1:0]  cell_load = 2'b00;
  logic [15:0] buf_rd_data;
  logic [1:0]  buf_rd_en;
  logic [5:0]  buf_rd_off;
  logic [4:0]  bus_addr = 5'd31;
  logic        bus_enb_n = 1'b1;
  logic        bus_clav, bus_clav_oe, bus_soc, bus_data_oe;
  logic [7:0]  bus_data;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  // buffer model: port 1 bytes carry bit 7 set, low bits are the offset
  assign buf_rd_data = {2'b10, buf_rd_off, 2'b00, buf_rd_off};

  cellbus_rx_phy u_cellbus_rx_phy (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cell_load(cell_load),
    .buf_rd_data(buf_rd_data), .buf_rd_en(buf_rd_en), .buf_rd_off(buf_rd_off),
    .bus_addr(bus_addr), .bus_enb_n(bus_enb_n), .bus_clav(bus_clav),
    .bus_clav_oe(bus_clav_oe), .bus_data(bus_data), .bus_soc(bus_soc),
    .bus_data_oe(bus_data_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [4:0] a, input logic en_n, input logic [1:0] ld);
    bus_addr = a; bus_enb_n = en_n; cell_load = ld;
  endtask

  task automatic expect_bus(input string tag, input logic coe, input logic clav,
                            input logic doe, input logic soc, input logic [7:0] dat);
    chk({tag, " clav_oe R2/R3"}, 8'(bus_clav_oe), 8'(coe));
    if (coe) chk({tag, " clav R2"}, 8'(bus_clav), 8'(clav));
    chk({tag, " data_oe R4/R9/R11"}, 8'(bus_data_oe), 8'(doe));
    chk({tag, " soc R6"}, 8'(bus_soc), 8'(soc));
    if (doe) chk({tag, " data R5/R10"}, bus_data, dat);
  endtask

  // {addr, enb_n, load[1:0], exp clav_oe, clav, data_oe, soc, 12'h0, exp data}
  localparam logic [31:0] VEC [18] = '{
    {5'd3,  1'b1, 2'b00, 4'b1000, 12'h0, 8'h00},
    {5'd9,  1'b1, 2'b01, 4'b1000, 12'h0, 8'h00},
    {5'd3,  1'b1, 2'b00, 4'b1100, 12'h0, 8'h00},
    {5'd7,  1'b1, 2'b00, 4'b0000, 12'h0, 8'h00},
    {5'd9,  1'b1, 2'b10, 4'b1000, 12'h0, 8'h00},
    {5'd9,  1'b1, 2'b00, 4'b1100, 12'h0, 8'h00},
    {5'd3,  1'b1, 2'b00, 4'b1100, 12'h0, 8'h00},
    {5'd9,  1'b0, 2'b00, 4'b1111, 12'h0, 8'h00},
    {5'd7,  1'b0, 2'b00, 4'b0010, 12'h0, 8'h01},
    {5'd3,  1'b1, 2'b00, 4'b1100, 12'h0, 8'h00},
    {5'd3,  1'b0, 2'b00, 4'b1110, 12'h0, 8'h02},
    {5'd7,  1'b1, 2'b00, 4'b0000, 12'h0, 8'h00},
    {5'd31, 1'b0, 2'b00, 4'b0000, 12'h0, 8'h00},
    {5'd31, 1'b0, 2'b00, 4'b0000, 12'h0, 8'h00},
    {5'd9,  1'b1, 2'b00, 4'b1100, 12'h0, 8'h00},
    {5'd0,  1'b0, 2'b00, 4'b0011, 12'h0, 8'h80},
    {5'd3,  1'b1, 2'b00, 4'b1100, 12'h0, 8'h00},
    {5'd0,  1'b0, 2'b00, 4'b0010, 12'h0, 8'h03}
  };

  function automatic string row_tag(input int i);
    case (i)
      9, 10:  return "R7 pause-resume";
      12, 13: return "R9 null select";
      15, 17: return "R10 port switch";
      7:      return "R4 select";
      default: return "R2 poll";
    endcase
  endfunction

  initial begin
    // R1: reset state
    repeat (3) step();
    expect_bus("R1 in reset", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    rst_n = 1'b1;
    repeat (4) step();
    expect_bus("R1 after reset", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);

    for (int i = 0; i < 18; i++) begin
      drive(VEC[i][31:27], VEC[i][26], VEC[i][25:24]);
      step();
      expect_bus(row_tag(i), VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][7:0]);
    end

    // R5: rest of the fast cell, R8: load lands on the last byte
    for (int k = 4; k < 53; k++) begin
      drive(5'd0, 1'b0, (k == 52) ? 2'b01 : 2'b00);
      step();
      expect_bus("R5 stream fast", 1'b0, 1'b0, 1'b1, 1'b0, 8'(k));
    end
    drive(5'd3, 1'b0, 2'b00);
    step();
    expect_bus("R8 reload kept, R6 wrap", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);

    // R10: back to interleaved port at offset 1
    drive(5'd9, 1'b1, 2'b00);
    step();
    expect_bus("R10 poll intl", 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    for (int k = 1; k < 53; k++) begin
      drive(5'd0, 1'b0, 2'b00);
      step();
      expect_bus("R10 stream intl", 1'b0, 1'b0, 1'b1, 1'b0, 8'(8'h80 | k));
    end
    // R8 cleared, R11 no cell no data
    drive(5'd9, 1'b0, 2'b00);
    step();
    expect_bus("R8 cleared R11 idle", 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);

    // R12: duplicate address, port 0 wins
    cfg_addr = {5'd3, 5'd3};
    drive(5'd3, 1'b1, 2'b00);
    step();
    expect_bus("R12 poll dup", 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    drive(5'd0, 1'b0, 2'b00);
    step();
    expect_bus("R12 select dup", 1'b0, 1'b0, 1'b1, 1'b0, 8'h01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule